// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one W-bit integer by another over several clock cycles and returns a W-bit quotient and a W-bit remainder. It does this with a single adder/subtractor of divisor width and one working register. Software-visible arithmetic, such as a processor's divide unit, pulses `start` with the two operands and a mode bit that selects signed or unsigned. It then waits for `done`. The quotient appears on `lo_quot`, the remainder on `hi_rem`, and `div_zero` reports a zero divisor.

The work is always done on magnitudes. At start, the dividend magnitude is loaded into the low half of a 2W+1-bit working register, with the upper part cleared, and the register is shifted left once. On each of the W iterations, the divisor is subtracted from the upper part. The borrow of that wide subtraction decides the step:
- If the divisor fits, the difference is written back and the register shifts left with a 1 entering at bit 0.
- If it does not fit, the old upper part is kept, which is the restore, and the register shifts left with a 0 entering.

Afterwards, the low half holds the quotient magnitude and the upper part shifted right by one holds the remainder magnitude. A final step applies the signs.

The controller has four states:
- `ST_IDLE`: waits for `start`.
- `ST_RUN`: one iteration per cycle, W cycles.
- `ST_ADJ`: sign fix-up and result write.
- `ST_DONE`: one-cycle completion pulse.

The transitions are:
- `ST_IDLE` to `ST_RUN` on `start` with a nonzero divisor.
- `ST_IDLE` to `ST_ADJ` on `start` with a zero divisor.
- `ST_RUN` to `ST_ADJ` after the last iteration.
- `ST_ADJ` to `ST_DONE` always.
- `ST_DONE` to `ST_IDLE` always.

Top module: `seq_divider`

## Requirements
- R1: After reset, `busy`, `done`, `div_zero`, `lo_quot` and `hi_rem` are all zero.
- R2: `start` is accepted only while the block is neither busy nor signalling done. A `start` raised during `busy` or during the `done` cycle has no effect on timing or results.
- R3: For a nonzero divisor, `busy` is high for exactly W+1 cycles, starting the cycle after `start` is accepted. `done` is then high for exactly one cycle, and `busy` and `done` are never high together.
- R4: In unsigned mode (`signed_mode`=0), `lo_quot` is the floor quotient and `hi_rem` the remainder over the full unsigned range of both operands.
- R5: In signed mode (`signed_mode`=1, operands two's complement), the quotient is truncated toward zero, so its magnitude is negated when the operand signs differ.
- R6: In signed mode, a nonzero remainder carries the sign of the dividend and is smaller in magnitude than the divisor.
- R7: In signed mode, the most negative dividend divided by -1 gives a quotient equal to the most negative value (bit W-1 set, others clear) and a remainder of zero.
- R8: A zero divisor gives the following behaviour:
  - `div_zero`=1, `busy` high for one cycle, then `done`.
  - `lo_quot` all ones and `hi_rem` equal to the dividend as given.
  - The next operation with a nonzero divisor clears `div_zero` at its `done`.
- R9: `lo_quot`, `hi_rem` and `div_zero` change only in the cycle `done` rises, and hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division when idle |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | W | Dividend, sampled with `start` |
| divisor | input | W | Divisor, sampled with `start` |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse; results valid |
| div_zero | output | 1 | Last completed division had a zero divisor |
| lo_quot | output | W | Quotient |
| hi_rem | output | W | Remainder |

## Verification
The bench targets operands near the top of the unsigned range. All-ones divided by all-ones and a dividend just under a divisor with bit W-1 set both expose a fit test that uses the sign of a W-bit field; such a design would give wrong quotients once the partial remainder reaches bit W-1. Signed cases cover every sign combination, the most negative dividend, and the overflow pair with -1. A misplaced sign fix-up there would give a remainder with the divisor's sign or a positive overflow result. Zero divisors in both modes check the early exit and the deterministic results. `start` pulses inside `busy` and on the `done` cycle check that a controller accepting them would restart with the intruding operands or stretch the timing.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_ADJ  = 2'd2,
        ST_DONE = 2'd3
    } div_state_e;

endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dvs_zero,
    output logic load_o,
    output logic step_o,
    output logic latch_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    div_state_e state_q, state_d;
    logic [CW-1:0] iter_q;
    logic          last_iter;

    assign last_iter = (iter_q == LAST);

    // state register and iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load_o)
                iter_q <= '0;
            else if (step_o)
                iter_q <= iter_q + 1'b1;
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = dvs_zero ? ST_ADJ : ST_RUN;
            ST_RUN:  if (last_iter) state_d = ST_ADJ;
            ST_ADJ:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o  = (state_q == ST_IDLE) && start;
        step_o  = (state_q == ST_RUN);
        latch_o = (state_q == ST_ADJ);
        busy_o  = (state_q == ST_RUN) || (state_q == ST_ADJ);
        done_o  = (state_q == ST_DONE);
    end

endmodule

// File: rtl/div_operand.sv
module div_operand #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         signed_mode,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] dvd_mag,
    output logic         dvs_zero,
    output logic [W-1:0] dvs_mag_q,
    output logic [W-1:0] dvd_raw_q,
    output logic         neg_q_q,
    output logic         neg_r_q,
    output logic         zero_q
);

    logic         dvd_neg, dvs_neg;
    logic [W-1:0] dvs_mag;

    assign dvd_neg  = signed_mode && dividend[W-1];
    assign dvs_neg  = signed_mode && divisor[W-1];
    assign dvd_mag  = dvd_neg ? (~dividend + 1'b1) : dividend;
    assign dvs_mag  = dvs_neg ? (~divisor + 1'b1) : divisor;
    assign dvs_zero = (divisor == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvs_mag_q <= '0;
            dvd_raw_q <= '0;
            neg_q_q   <= 1'b0;
            neg_r_q   <= 1'b0;
            zero_q    <= 1'b0;
        end else if (load) begin
            dvs_mag_q <= dvs_mag;
            dvd_raw_q <= dividend;
            neg_q_q   <= dvd_neg ^ dvs_neg;
            neg_r_q   <= dvd_neg;
            zero_q    <= dvs_zero;
        end
    end

endmodule

// File: rtl/div_core.sv
module div_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dvd_mag,
    input  logic [W-1:0] dvs_mag,
    output logic [W-1:0] quo_mag,
    output logic [W-1:0] rem_mag
);

    localparam int AW = 2 * W + 1;

    logic [AW-1:0] acc_q;
    logic [W:0]    upper;
    logic [W+1:0]  diff;
    logic          fits;

    assign upper = acc_q[AW-1:W];
    assign diff  = {1'b0, upper} - {2'b00, dvs_mag};
    assign fits  = ~diff[W+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (load) begin
            acc_q <= {{W{1'b0}}, dvd_mag, 1'b0};
        end else if (step) begin
            if (fits)
                acc_q <= {diff[W-1:0], acc_q[W-1:0], 1'b1};
            else
                acc_q <= {acc_q[AW-2:0], 1'b0};
        end
    end

    assign quo_mag = acc_q[W-1:0];
    assign rem_mag = acc_q[AW-1:W+1];

endmodule

// File: rtl/div_result.sv
module div_result #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         latch,
    input  logic         zero,
    input  logic         neg_q,
    input  logic         neg_r,
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    input  logic [W-1:0] dvd_raw,
    output logic [W-1:0] quo_q,
    output logic [W-1:0] rem_q,
    output logic         zero_flag_q
);

    logic [W-1:0] quo_fix, rem_fix;

    always_comb begin
        if (zero) begin
            quo_fix = '1;
            rem_fix = dvd_raw;
        end else begin
            quo_fix = neg_q ? (~quo_mag + 1'b1) : quo_mag;
            rem_fix = neg_r ? (~rem_mag + 1'b1) : rem_mag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_q       <= '0;
            rem_q       <= '0;
            zero_flag_q <= 1'b0;
        end else if (latch) begin
            quo_q       <= quo_fix;
            rem_q       <= rem_fix;
            zero_flag_q <= zero;
        end
    end

endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         signed_mode,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic         div_zero,
    output logic [W-1:0] lo_quot,
    output logic [W-1:0] hi_rem
);

    logic         load, step, latch;
    logic         dvs_zero;
    logic [W-1:0] dvd_mag, dvs_mag_q, dvd_raw_q;
    logic         neg_q_q, neg_r_q, zero_q;
    logic [W-1:0] quo_mag, rem_mag;

    div_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dvs_zero (dvs_zero),
        .load_o   (load),
        .step_o   (step),
        .latch_o  (latch),
        .busy_o   (busy),
        .done_o   (done)
    );

    div_operand #(.W(W)) u_operand (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .signed_mode (signed_mode),
        .dividend    (dividend),
        .divisor     (divisor),
        .dvd_mag     (dvd_mag),
        .dvs_zero    (dvs_zero),
        .dvs_mag_q   (dvs_mag_q),
        .dvd_raw_q   (dvd_raw_q),
        .neg_q_q     (neg_q_q),
        .neg_r_q     (neg_r_q),
        .zero_q      (zero_q)
    );

    div_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .dvd_mag (dvd_mag),
        .dvs_mag (dvs_mag_q),
        .quo_mag (quo_mag),
        .rem_mag (rem_mag)
    );

    div_result #(.W(W)) u_result (
        .clk         (clk),
        .rst_n       (rst_n),
        .latch       (latch),
        .zero        (zero_q),
        .neg_q       (neg_q_q),
        .neg_r       (neg_r_q),
        .quo_mag     (quo_mag),
        .rem_mag     (rem_mag),
        .dvd_raw     (dvd_raw_q),
        .quo_q       (lo_quot),
        .rem_q       (hi_rem),
        .zero_flag_q (div_zero)
    );

endmodule

// File: rtl/div_checker.sv
module div_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic         div_zero,
    input logic [W-1:0] lo_quot,
    input logic [W-1:0] hi_rem
);

    localparam int CW = $clog2(W + 3);

    logic [CW-1:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            busy_len <= '0;
        else if (busy)
            busy_len <= busy_len + 1'b1;
        else if (!done)
            busy_len <= '0;
    end

    // R3
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero) |-> (busy_len == CW'(W + 1)));

    // R8
    zero_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (busy_len == CW'(1)));

    // R8
    zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (lo_quot == '1));

    // R2
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lo_quot != $past(lo_quot)) || (hi_rem != $past(hi_rem))
         || (div_zero != $past(div_zero))) |-> done);

endmodule

bind seq_divider div_checker #(.W(W)) u_div_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .div_zero (div_zero),
    .lo_quot  (lo_quot),
    .hi_rem   (hi_rem)
);

// File: tb/test_seq_divider.sv
`timescale 1ns/1ps
module test_seq_divider;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         signed_mode = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_zero;
    logic [W-1:0] lo_quot, hi_rem;

    int checks = 0;
    int errors = 0;
    bit monitor_on = 1'b0;
    bit finished = 1'b0;

    bit exp_busy_q[$];
    bit exp_done_q[$];

    always #2.5 clk = ~clk;

    seq_divider #(.W(W)) i_seq_divider (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .signed_mode (signed_mode),
        .dividend    (dividend),
        .divisor     (divisor),
        .busy        (busy),
        .done        (done),
        .div_zero    (div_zero),
        .lo_quot     (lo_quot),
        .hi_rem      (hi_rem)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // reference: busy/done timeline compared on every clock (R2, R3, R8)
    always @(negedge clk) begin
        if (monitor_on) begin
            bit eb, ed;
            eb = 1'b0;
            ed = 1'b0;
            if (exp_busy_q.size() > 0) begin
                eb = exp_busy_q.pop_front();
                ed = exp_done_q.pop_front();
            end
            check("R3", "busy", W'(busy), W'(eb));
            check("R3", "done", W'(done), W'(ed));
        end
    end

    function automatic void ref_div(input logic [W-1:0] a, input logic [W-1:0] b,
                                    input bit sgn, output logic [W-1:0] q,
                                    output logic [W-1:0] r, output bit z);
        longint sa, sb;
        z = (b == '0);
        if (z) begin
            q = '1;
            r = a;
        end else if (!sgn) begin
            q = a / b;
            r = a % b;
        end else begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            q = W'(sa / sb);
            r = W'(sa % sb);
        end
    endfunction

    // one division; poke raises stray start pulses during busy and on done
    task automatic run_div(input string req, input logic [W-1:0] a,
                           input logic [W-1:0] b, input bit sgn, input bit poke);
        logic [W-1:0] eq, er;
        bit ez;
        int len;
        ref_div(a, b, sgn, eq, er, ez);
        len = ez ? 2 : W + 2;
        @(posedge clk);
        #1;
        start = 1'b1;
        signed_mode = sgn;
        dividend = a;
        divisor = b;
        exp_busy_q.push_back(1'b0);
        exp_done_q.push_back(1'b0);
        for (int i = 1; i < len; i++) begin
            exp_busy_q.push_back(1'b1);
            exp_done_q.push_back(1'b0);
        end
        exp_busy_q.push_back(1'b0);
        exp_done_q.push_back(1'b1);
        @(posedge clk);
        #1;
        start = 1'b0;
        dividend = ~a;
        divisor = 32'h3;
        signed_mode = ~sgn;
        for (int k = 1; k <= len; k++) begin
            @(negedge clk);
            if (poke && (k == 1)) start = 1'b1;  // R2: stray start while busy
            if (poke && (k == 2)) start = 1'b0;
            if (k == len) begin
                check(req, "quotient", lo_quot, eq);
                check(req, "remainder", hi_rem, er);
                check(ez ? "R8" : req, "div_zero", W'(div_zero), W'(ez));
                if (poke) start = 1'b1;          // R2: stray start on done cycle
            end
        end
        @(negedge clk);
        start = 1'b0;
        // R9: results hold after completion
        repeat (3) @(negedge clk);
        check("R9", "held quotient", lo_quot, eq);
        check("R9", "held remainder", hi_rem, er);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "busy", W'(busy), '0);
        check("R1", "done", W'(done), '0);
        check("R1", "div_zero", W'(div_zero), '0);
        check("R1", "lo_quot", lo_quot, '0);
        check("R1", "hi_rem", hi_rem, '0);
        monitor_on = 1'b1;

        // R4 unsigned, full range
        run_div("R4", 32'd100, 32'd7, 1'b0, 1'b0);
        run_div("R4", 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0);
        run_div("R4", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0);
        run_div("R4", 32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, 1'b0);
        run_div("R4", 32'h8000_0000, 32'd3, 1'b0, 1'b0);
        run_div("R4", 32'hF234_5678, 32'h8000_0001, 1'b0, 1'b0);
        run_div("R4", 32'd5, 32'd10, 1'b0, 1'b0);

        // R5 / R6 signed combinations
        run_div("R5", 32'hFFFF_FFF9, 32'd2, 1'b1, 1'b0);          // -7 / 2
        run_div("R5", 32'd7, 32'hFFFF_FFFE, 1'b1, 1'b0);          // 7 / -2
        run_div("R6", 32'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b1, 1'b0);  // -7 / -2
        run_div("R6", 32'hFFFF_FFF8, 32'd2, 1'b1, 1'b0);          // -8 / 2
        run_div("R5", 32'h8000_0000, 32'd1, 1'b1, 1'b0);
        run_div("R5", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0);
        run_div("R6", 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b0);

        // R7 signed overflow
        run_div("R7", 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0);

        // R8 zero divisor, both modes, then cleared by a normal divide
        run_div("R8", 32'd1234, 32'd0, 1'b0, 1'b0);
        run_div("R8", 32'hFFFF_FFFB, 32'd0, 1'b1, 1'b0);
        run_div("R8", 32'd9, 32'd4, 1'b0, 1'b0);

        // R2 stray start pulses ignored
        run_div("R2", 32'd1_000_000, 32'd37, 1'b0, 1'b1);
        run_div("R2", 32'hFFFF_0000, 32'd0, 1'b1, 1'b1);

        // mixed operands
        for (int n = 0; n < 40; n++) begin
            logic [W-1:0] a, b;
            bit s;
            a = $urandom();
            b = (n % 3 == 0) ? ($urandom() >> (n % 31)) : $urandom();
            s = n[0];
            run_div(s ? "R5" : "R4", a, b, s, 1'b0);
        end

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule